// File: doc/BRIEF.md
# Bit-Stuffing NRZI Serial Transmitter

This block turns a stream of packet bytes into a single serial line state for a differential serial link. Bytes arrive on a ready/valid byte interface. The block sends them least significant bit first, after a fixed synchronisation pattern. Before encoding, it inserts a zero after any run of six ones. It then encodes the stuffed stream as NRZI: a 0 toggles the line level and a 1 holds it. A packet is closed by a single-ended-zero marker followed by one idle bit.

All bit-level progress is paced by a one-cycle bit-rate enable from outside, so the core clock can run at any multiple of the bit rate. Between packets the line rests at the idle level (J, line level 1). A new packet begins at the first bit slot in which a byte is offered.

Top module: `nrzi_stuff_tx`

## Requirements
- R1: After reset, and in every bit slot while no byte is offered, `line_out` is 1, `se0_out` is 0 and `in_ready` is 0.
- R2: In each data or sync bit slot, a transmitted 0 inverts `line_out` and a transmitted 1 leaves it unchanged. `se0_out` is 0 in these slots.
- R3: A packet starts in the first bit slot in which `in_valid` is high while the block is idle. Its first eight bit slots carry the sync bits 0,0,0,0,0,0,0,1 in that order, starting from line level 1.
- R4: Data bytes follow the sync field least significant bit first. A byte is taken (`in_valid` and `in_ready` both high) only in the bit slot that sends its bit 0, so `in_ready` is high only in cycles where `bit_en` is high.
- R5: Once six consecutive 1 bits have been sent, the next bit slot sends a stuffed 0. The run count includes the final sync 1, spans byte boundaries, and is cleared by any sent 0, stuffed or not.
- R6: `line_out` and `se0_out` change only on clock edges at which `bit_en` is high.
- R7: During a stuffed-bit slot `in_ready` is low, and the following data bit, or the next byte, moves one slot later.
- R8: After the bit slots of the byte marked with `in_last`, the block drives `se0_out`=1 (with `line_out`=0) for two bit slots. It then drives one slot of `line_out`=1, `se0_out`=0 and returns to idle.
- R9: If `in_valid` is low in the slot where the next byte would be taken, the packet closes exactly as in R8.
- R10: A new packet may start in the bit slot directly after the idle slot that ends the previous packet.
- R11: If the last data bit completes a run of six ones, the stuffed 0 is sent before the first single-ended-zero slot.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | One-cycle pulse marking a bit slot |
| in_data | input | 8 | Packet byte offered |
| in_valid | input | 1 | Byte offered |
| in_last | input | 1 | Offered byte is the final byte of the packet |
| in_ready | output | 1 | Byte taken in this cycle when `in_valid` is high |
| line_out | output | 1 | NRZI-encoded line level |
| se0_out | output | 1 | Single-ended-zero marker |

## Verification
Stuffing can collide with byte handling. A stuffed zero can fall in the same slot where a new byte would be taken, or in the slot where the end marker would start. The bench provokes both cases with directed bytes: 0xFF runs that cross byte boundaries, and a final 0xFC whose last six ones force a stuff just ahead of the end marker. It also sends random packets with many 0xFF bytes, at random bit-enable spacing that includes back-to-back pulses. The result is judged by comparing the whole per-slot sequence of line and marker levels against a bench model that stuffs and encodes the bits. Each packet's count of accepted bytes is also checked.

// File: rtl/nrzi_tx_pkg.sv
package nrzi_tx_pkg;
  typedef enum logic [2:0] {
    TX_IDLE  = 3'd0,
    TX_SYNC  = 3'd1,
    TX_DATA  = 3'd2,
    TX_EOP   = 3'd3,
    TX_JTAIL = 3'd4
  } tx_state_e;
endpackage

// File: rtl/nrzi_tx_framer.sv
module nrzi_tx_framer
  import nrzi_tx_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int SYNC_LEN = 8,
  parameter int EOP_LEN  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_en,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_valid,
  input  logic              in_last,
  input  logic              stuff_now,
  output logic              in_ready,
  output logic              in_packet,
  output logic              src_valid,
  output logic              src_bit,
  output logic              se0_slot,
  output logic              j_slot
);
  localparam int BIT_IW  = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam int SYNC_CW = (SYNC_LEN > 1) ? $clog2(SYNC_LEN) : 1;
  localparam int EOP_CW  = (EOP_LEN > 1) ? $clog2(EOP_LEN) : 1;
  localparam logic [BIT_IW-1:0]  LAST_IDX  = BIT_IW'(DATA_W - 1);
  localparam logic [SYNC_CW-1:0] SYNC_LAST = SYNC_CW'(SYNC_LEN - 1);
  localparam logic [EOP_CW-1:0]  EOP_LAST  = EOP_CW'(EOP_LEN - 1);

  tx_state_e          state;
  logic [BIT_IW-1:0]  bit_idx;
  logic [SYNC_CW-1:0] sync_cnt;
  logic [EOP_CW-1:0]  eop_cnt;
  logic [DATA_W-1:0]  shreg;
  logic               last_q;

  assign in_packet = (state == TX_SYNC) || (state == TX_DATA);

  always_comb begin
    src_valid = 1'b0;
    src_bit   = 1'b0;
    se0_slot  = 1'b0;
    j_slot    = 1'b0;
    in_ready  = 1'b0;
    case (state)
      TX_IDLE: begin
        if (in_valid) begin
          src_valid = 1'b1;
          src_bit   = 1'b0;
        end else begin
          j_slot = 1'b1;
        end
      end
      TX_SYNC: begin
        if (!stuff_now) begin
          src_valid = 1'b1;
          src_bit   = (sync_cnt == SYNC_LAST);
        end
      end
      TX_DATA: begin
        if (!stuff_now) begin
          if (bit_idx == '0) begin
            if (last_q) begin
              se0_slot = 1'b1;
            end else begin
              in_ready = bit_en;
              if (in_valid) begin
                src_valid = 1'b1;
                src_bit   = in_data[0];
              end else begin
                se0_slot = 1'b1;
              end
            end
          end else begin
            src_valid = 1'b1;
            src_bit   = shreg[bit_idx];
          end
        end
      end
      TX_EOP:   se0_slot = 1'b1;
      TX_JTAIL: j_slot   = 1'b1;
      default:  j_slot   = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= TX_IDLE;
      bit_idx  <= '0;
      sync_cnt <= '0;
      eop_cnt  <= '0;
      shreg    <= '0;
      last_q   <= 1'b0;
    end else if (bit_en) begin
      case (state)
        TX_IDLE: begin
          if (in_valid) begin
            state    <= TX_SYNC;
            sync_cnt <= SYNC_CW'(1);
            last_q   <= 1'b0;
            bit_idx  <= '0;
          end
        end
        TX_SYNC: begin
          if (!stuff_now) begin
            if (sync_cnt == SYNC_LAST) begin
              state   <= TX_DATA;
              bit_idx <= '0;
            end else begin
              sync_cnt <= sync_cnt + 1'b1;
            end
          end
        end
        TX_DATA: begin
          if (!stuff_now) begin
            if (bit_idx == '0) begin
              if (last_q || !in_valid) begin
                state   <= TX_EOP;
                eop_cnt <= EOP_CW'(1);
              end else begin
                shreg   <= in_data;
                last_q  <= in_last;
                bit_idx <= BIT_IW'(1);
              end
            end else if (bit_idx == LAST_IDX) begin
              bit_idx <= '0;
            end else begin
              bit_idx <= bit_idx + 1'b1;
            end
          end
        end
        TX_EOP: begin
          if (eop_cnt == EOP_LAST) state <= TX_JTAIL;
          else                     eop_cnt <= eop_cnt + 1'b1;
        end
        TX_JTAIL: state <= TX_IDLE;
        default:  state <= TX_IDLE;
      endcase
    end
  end

  // R4: a byte is only taken inside an active bit slot of the data phase
  assert_take_in_slot_R4: assert property (@(posedge clk) disable iff (rst)
    (in_ready && in_valid) |=> (state == TX_DATA) || (state == TX_EOP));
endmodule

// File: rtl/nrzi_tx_stuffer.sv
module nrzi_tx_stuffer #(
  parameter int STUFF_RUN = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_en,
  input  logic active,
  input  logic src_valid,
  input  logic src_bit,
  output logic stuff_now
);
  localparam int RW = $clog2(STUFF_RUN + 1);
  localparam logic [RW-1:0] RUN_MAX = RW'(STUFF_RUN);

  logic [RW-1:0] run_cnt;

  assign stuff_now = active && (run_cnt == RUN_MAX);

  always_ff @(posedge clk) begin
    if (rst) begin
      run_cnt <= '0;
    end else if (bit_en) begin
      if (stuff_now)                  run_cnt <= '0;
      else if (src_valid && src_bit)  run_cnt <= run_cnt + 1'b1;
      else                            run_cnt <= '0;
    end
  end

  // R5: the framer never sends a one once the run is full
  assert_no_seventh_one_R5: assert property (@(posedge clk) disable iff (rst)
    (bit_en && src_valid && src_bit) |-> (run_cnt < RUN_MAX));
endmodule

// File: rtl/nrzi_tx_line.sv
module nrzi_tx_line (
  input  logic clk,
  input  logic rst,
  input  logic bit_en,
  input  logic send_valid,
  input  logic send_bit,
  input  logic se0_slot,
  input  logic j_slot,
  output logic line_out,
  output logic se0_out
);
  always_ff @(posedge clk) begin
    if (rst) begin
      line_out <= 1'b1;
      se0_out  <= 1'b0;
    end else if (bit_en) begin
      if (se0_slot) begin
        se0_out  <= 1'b1;
        line_out <= 1'b0;
      end else if (j_slot) begin
        se0_out  <= 1'b0;
        line_out <= 1'b1;
      end else if (send_valid) begin
        se0_out  <= 1'b0;
        line_out <= send_bit ? line_out : ~line_out;
      end
    end
  end

  assert_zero_toggles_R2: assert property (@(posedge clk) disable iff (rst)
    (bit_en && send_valid && !send_bit && !se0_slot && !j_slot)
      |=> (line_out != $past(line_out)));

  assert_hold_between_slots_R6: assert property (@(posedge clk) disable iff (rst)
    !bit_en |=> ($stable(line_out) && $stable(se0_out)));

  assert_j_after_se0_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(se0_out) |-> line_out);
endmodule

// File: rtl/nrzi_stuff_tx.sv
module nrzi_stuff_tx #(
  parameter int DATA_W    = 8,
  parameter int SYNC_LEN  = 8,
  parameter int STUFF_RUN = 6,
  parameter int EOP_LEN   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_en,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_valid,
  input  logic              in_last,
  output logic              in_ready,
  output logic              line_out,
  output logic              se0_out
);
  logic in_packet;
  logic src_valid;
  logic src_bit;
  logic se0_slot;
  logic j_slot;
  logic stuff_now;
  logic send_valid;
  logic send_bit;

  nrzi_tx_framer #(
    .DATA_W  (DATA_W),
    .SYNC_LEN(SYNC_LEN),
    .EOP_LEN (EOP_LEN)
  ) u_framer (
    .clk      (clk),
    .rst      (rst),
    .bit_en   (bit_en),
    .in_data  (in_data),
    .in_valid (in_valid),
    .in_last  (in_last),
    .stuff_now(stuff_now),
    .in_ready (in_ready),
    .in_packet(in_packet),
    .src_valid(src_valid),
    .src_bit  (src_bit),
    .se0_slot (se0_slot),
    .j_slot   (j_slot)
  );

  nrzi_tx_stuffer #(
    .STUFF_RUN(STUFF_RUN)
  ) u_stuffer (
    .clk      (clk),
    .rst      (rst),
    .bit_en   (bit_en),
    .active   (in_packet),
    .src_valid(src_valid),
    .src_bit  (src_bit),
    .stuff_now(stuff_now)
  );

  assign send_valid = src_valid | stuff_now;
  assign send_bit   = src_bit & ~stuff_now;

  nrzi_tx_line u_line (
    .clk       (clk),
    .rst       (rst),
    .bit_en    (bit_en),
    .send_valid(send_valid),
    .send_bit  (send_bit),
    .se0_slot  (se0_slot),
    .j_slot    (j_slot),
    .line_out  (line_out),
    .se0_out   (se0_out)
  );

  // R7: no byte is taken while a stuffed zero occupies the slot
  assert_ready_no_stuff_R7: assert property (@(posedge clk) disable iff (rst)
    in_ready |-> !stuff_now);

  // R8: each bit slot carries exactly one kind of line action at most
  assert_single_action_R8: assert property (@(posedge clk) disable iff (rst)
    bit_en |-> $onehot0({src_valid, stuff_now, se0_slot, j_slot}));
endmodule

// File: tb/nrzi_stuff_tx_bench.sv
module nrzi_stuff_tx_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bit_en = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic       in_valid = 1'b0;
  logic       in_last = 1'b0;
  logic       in_ready;
  logic       line_out;
  logic       se0_out;

  nrzi_stuff_tx u_nrzi_stuff_tx (
    .clk     (clk),
    .rst     (rst),
    .bit_en  (bit_en),
    .in_data (in_data),
    .in_valid(in_valid),
    .in_last (in_last),
    .in_ready(in_ready),
    .line_out(line_out),
    .se0_out (se0_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  int ready_bad = 0;
  int hold_bad  = 0;
  logic be_q = 1'b0;
  logic hs_q = 1'b0;
  logic prev_line = 1'b1;
  logic prev_se0  = 1'b0;
  int   gap = 0;

  logic [7:0] pkt [16];
  bit         exp_l [512];
  bit         exp_s [512];
  int         exp_len;

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    be_q <= bit_en;
    hs_q <= in_valid & in_ready;
    if (!rst && in_ready && !bit_en) ready_bad++;
    if (cycles > WATCHDOG) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, WATCHDOG);
      summary();
    end
  end

  // bit-rate enable with random spacing, back-to-back pulses included
  always @(negedge clk) begin
    if (gap == 0) begin
      bit_en <= 1'b1;
      gap = $urandom_range(0, 3);
    end else begin
      bit_en <= 1'b0;
      gap--;
    end
  end

  // R6 monitor: outputs move only after an edge with bit_en high
  always @(negedge clk) begin
    if (!rst && !be_q && (line_out != prev_line || se0_out != prev_se0)) hold_bad++;
    prev_line = line_out;
    prev_se0  = se0_out;
  end

  task automatic build_expected(input int n, input bit tail_idle);
    bit raw [512];
    int rn = 0;
    int ones = 0;
    bit lvl = 1'b1;
    for (int i = 0; i < 8; i++) begin
      raw[rn] = (i == 7); rn++;
      if (i == 7) ones++; else ones = 0;
    end
    for (int b = 0; b < n; b++) begin
      for (int k = 0; k < 8; k++) begin
        raw[rn] = pkt[b][k]; rn++;
        if (pkt[b][k]) ones++; else ones = 0;
        if (ones == 6) begin
          raw[rn] = 1'b0; rn++;
          ones = 0;
        end
      end
    end
    exp_len = 0;
    for (int i = 0; i < rn; i++) begin
      if (!raw[i]) lvl = ~lvl;
      exp_l[exp_len] = lvl; exp_s[exp_len] = 1'b0; exp_len++;
    end
    for (int i = 0; i < 2; i++) begin
      exp_l[exp_len] = 1'b0; exp_s[exp_len] = 1'b1; exp_len++;
    end
    exp_l[exp_len] = 1'b1; exp_s[exp_len] = 1'b0; exp_len++;
    if (tail_idle) begin
      exp_l[exp_len] = 1'b1; exp_s[exp_len] = 1'b0; exp_len++;
    end
  endtask

  // called at a falling edge; offers the bytes and records every bit slot
  task automatic run_packet(input int n, input bit use_last, input bit tail_idle, input string tag);
    int idx = 0;
    int got = 0;
    int hs  = 0;
    int mism = -1;
    int act_v = 0;
    int exp_v = 0;
    build_expected(n, tail_idle);
    in_valid = 1'b1;
    in_data  = pkt[0];
    in_last  = use_last && (n == 1);
    while (got < exp_len) begin
      @(negedge clk);
      if (hs_q) begin
        hs++;
        idx++;
        if (idx < n) begin
          in_data = pkt[idx];
          in_last = use_last && (idx == n - 1);
        end else begin
          in_valid = 1'b0;
          in_last  = 1'b0;
        end
      end
      if (be_q) begin
        if (mism < 0 && (line_out != exp_l[got] || se0_out != exp_s[got])) begin
          mism  = got;
          act_v = {se0_out, line_out};
          exp_v = {exp_s[got], exp_l[got]};
        end
        got++;
      end
    end
    in_valid = 1'b0;
    if (mism >= 0) $display("  slot %0d of %s: {se0,line}", mism, tag);
    check(mism < 0, tag, act_v, exp_v);
    check(hs == n, "R4 bytes taken", hs, n);
  endtask

  initial begin
    void'($urandom(32'd20240613));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check(line_out == 1'b1, "R1 line after reset", line_out, 1);
    check(se0_out == 1'b0, "R1 se0 after reset", se0_out, 0);
    check(in_ready == 1'b0, "R1 ready after reset", in_ready, 0);
    // R1: idle slots with nothing offered stay at J
    begin
      int idle_seen = 0;
      int idle_bad = 0;
      while (idle_seen < 5) begin
        @(negedge clk);
        if (be_q) begin
          idle_seen++;
          if (line_out !== 1'b1 || se0_out !== 1'b0) idle_bad++;
        end
      end
      check(idle_bad == 0, "R1 idle slots", idle_bad, 0);
    end

    // R3 R2: single zero byte, sync and plain NRZI
    pkt[0] = 8'h00;
    run_packet(1, 1'b1, 1'b1, "R3 R2 R8 sync+zero byte");
    // R5 R7: ones spanning bytes, stuffs landing on byte boundaries
    pkt[0] = 8'hFF; pkt[1] = 8'hFF; pkt[2] = 8'hFF;
    run_packet(3, 1'b1, 1'b1, "R5 R7 ones across bytes");
    // R5: sync's final one joins the first byte's run
    pkt[0] = 8'h3F; pkt[1] = 8'h81;
    run_packet(2, 1'b1, 1'b1, "R5 run counts sync one");
    // R11: last data bits complete a run, stuff precedes end marker
    pkt[0] = 8'h12; pkt[1] = 8'hFC;
    run_packet(2, 1'b1, 1'b1, "R11 stuff before SE0");
    // R4: bit order check with asymmetric byte
    pkt[0] = 8'h01; pkt[1] = 8'h80; pkt[2] = 8'hA5;
    run_packet(3, 1'b1, 1'b1, "R4 LSB first");
    // R9: no last flag, packet closes on underrun
    pkt[0] = 8'h5A; pkt[1] = 8'hFC;
    run_packet(2, 1'b0, 1'b1, "R9 underrun close R11");
    // R10: back-to-back packets
    pkt[0] = 8'hC3;
    run_packet(1, 1'b1, 1'b0, "R10 first of pair");
    pkt[0] = 8'h7E; pkt[1] = 8'h3F;
    run_packet(2, 1'b1, 1'b1, "R10 second of pair");

    // random packets mixed with ones-heavy bytes
    for (int p = 0; p < 24; p++) begin
      int n = $urandom_range(1, 6);
      for (int b = 0; b < n; b++)
        pkt[b] = ($urandom_range(0, 2) == 0) ? 8'hFF : 8'($urandom);
      run_packet(n, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                 "R2 R5 R8 random packet");
    end

    check(ready_bad == 0, "R4 ready only with bit_en", ready_bad, 0);
    check(hold_bad == 0, "R6 outputs change only on bit slots", hold_bad, 0);
    summary();
  end
endmodule